// File: doc/BRIEF.md
# Clock Buffer Power and Output Control

This block holds the digital control of a multi-output differential clock fan-out buffer. It watches one combined power-good / power-down input. The first rising edge of that input after reset captures two strap inputs: the PLL mode (low bandwidth, bypass or high bandwidth) and the frequency select. The block then starts running. Every later rising edge only brings the device out of power-down. A low level puts it back into power-down.

From the running state and a bank of per-output enable bits, the block produces a gate enable for each of the 15 clock outputs, a gate enable for the feedback output, and a PLL enable. A gate changes only while its output clock is reported low, so that no runt pulses appear. A small parallel register port writes the enable bits and reads back the latched straps. The analog PLL, the differential I/O, the tri-level voltage sensing and the serial management protocol are outside this block. It receives straps that are already decoded.

Top module: `clkbuf_ctrl`

## Requirements
- R1: After reset, and until the first rising edge of `pwr_ok`, every `out_gate` bit, `fb_gate` and `pll_en` are 0, whatever the enable bits hold.
- R2: On the first rising edge of `pwr_ok`, the block latches `mode_strap` and `freq_strap`. Register address 0 reads back as follows: bits 7:6 hold the mode (00 = PLL low bandwidth, 01 = bypass, 11 = PLL high bandwidth, and a strap of 10 is stored as 01), bit 5 holds the frequency select (1 = 100 MHz, 0 = 133.33 MHz), and bits 4:0 read 0.
- R3: Later rising edges of `pwr_ok` leave the latched mode and frequency unchanged, even if the straps have changed.
- R4: While `pwr_ok` is low after start-up, all `out_gate` bits, `fb_gate` and `pll_en` are 0, whatever the enable bits hold.
- R5: While running, `out_gate[i]` equals enable bit i. Outputs 0 to 7 are enabled by bits 7:0 at address 1, and outputs 8 to 14 by bits 6:0 at address 2. All enable bits reset to 1.
- R6: While running, `fb_gate` is 1, whatever the enable bits hold.
- R7: `pll_en` is 1 only while running with a latched mode other than bypass (01).
- R8: A gate output changes only in a cycle after its `*_clk_low` input was 1. While that input is 0, the gate holds its value.
- R9: Writes to address 0 or 3 change no enable bit. Bit 7 of address 2 and all of address 3 read 0. `reg_rdata` shows the register selected by `reg_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Combined power-good (high) / power-down (low), asynchronous |
| mode_strap | input | 2 | Decoded PLL mode strap |
| freq_strap | input | 1 | Frequency select strap |
| out_clk_low | input | 15 | Per output: its clock is currently low |
| fb_clk_low | input | 1 | Feedback clock is currently low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| out_gate | output | 15 | Per-output clock gate enable |
| fb_gate | output | 1 | Feedback output gate enable |
| pll_en | output | 1 | PLL enable |

## Verification
Each of the four strap codes is started from reset, with enable writes made beforehand. This separates strap capture and the mapping of 10 to bypass from gating that must stay off before start-up. Power cycles with straps changed in between show whether a re-latch happens on a later edge. Random mixes of enable writes, writes to read-only or unused addresses, power toggles and strap changes separate correct per-output gating from bit-mapping mistakes and from gating that leaks through power-down. A directed case holds one output's clock high while its enable changes, which tells glitch-safe gating apart from immediate gating.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
  typedef enum logic [1:0] {
    PLL_LOW_BW  = 2'b00,
    PLL_BYPASS  = 2'b01,
    PLL_HIGH_BW = 2'b11
  } pll_mode_e;

  // map a decoded strap onto a legal mode; the unused code means bypass
  function automatic pll_mode_e strap_to_mode(input logic [1:0] s);
    case (s)
      2'b00:   return PLL_LOW_BW;
      2'b11:   return PLL_HIGH_BW;
      default: return PLL_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/cb_pwr_seq.sv
module cb_pwr_seq
  import clkbuf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pwr_ok,
  input  logic [1:0] mode_strap,
  input  logic      freq_strap,
  output logic      run,
  output logic      pll_en,
  output pll_mode_e mode_q,
  output logic      freq_q
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         pg_prev_q;
  logic         started_q;
  logic         run_q;
  logic         pll_q;
  logic         pg_s;
  logic         pg_rise;

  assign pg_s    = sync_q[MSB];
  assign pg_rise = pg_s & ~pg_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      pg_prev_q <= 1'b0;
    end else begin
      sync_q    <= {sync_q[MSB-1:0], pwr_ok};
      pg_prev_q <= pg_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      mode_q    <= PLL_LOW_BW;
      freq_q    <= 1'b0;
      run_q     <= 1'b0;
    end else begin
      if (pg_rise && !started_q) begin
        started_q <= 1'b1;
        mode_q    <= strap_to_mode(mode_strap);
        freq_q    <= freq_strap;
      end
      if (pg_rise)
        run_q <= 1'b1;
      else if (!pg_s)
        run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pll_q <= 1'b0;
    else     pll_q <= run_q && (mode_q != PLL_BYPASS);
  end

  assign run    = run_q;
  assign pll_en = pll_q;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    started_q |=> ($stable(mode_q) && $stable(freq_q))); // R3
  AST_PLL_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PLL_BYPASS) |=> !pll_en); // R7
  AST_PLL_NOT_RUN: assert property (@(posedge clk) disable iff (rst)
    !started_q |=> !pll_en); // R1
endmodule

// File: rtl/cb_regfile.sv
module cb_regfile
  import clkbuf_pkg::*;
#(
  parameter int NUM_OUT = 15,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  pll_mode_e         mode_q,
  input  logic              freq_q,
  output logic [7:0]        reg_rdata,
  output logic [NUM_OUT-1:0] enables
);
  localparam int EN_BYTES = (NUM_OUT + 7) / 8;
  localparam int PAD_W    = EN_BYTES * 8;

  logic [NUM_OUT-1:0] en_q, en_d;
  logic [PAD_W-1:0]   en_pad;
  logic [7:0]         rd_d, rd_q;

  always_comb begin
    en_d = en_q;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (reg_we && (reg_addr == ADDR_W'(i / 8 + 1)))
        en_d[i] = reg_wdata[i % 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '1;
    else     en_q <= en_d;
  end

  assign en_pad = PAD_W'(en_q);

  always_comb begin
    rd_d = 8'h00;
    if (reg_addr == '0)
      rd_d = {mode_q, freq_q, 5'b0};
    for (int b = 0; b < EN_BYTES; b++) begin
      if (reg_addr == ADDR_W'(b + 1))
        rd_d = en_pad[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 8'h00;
    else     rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;
  assign enables   = en_q;

  AST_ADDR0_RO: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0) |=> $stable(en_q)); // R9
endmodule

// File: rtl/cb_gate.sv
module cb_gate (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic clk_low,
  output logic gate
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst)          gate_q <= 1'b0;
    else if (clk_low) gate_q <= want;
  end

  assign gate = gate_q;

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clk_low |=> $stable(gate_q)); // R8
endmodule

// File: rtl/clkbuf_ctrl.sv
module clkbuf_ctrl
  import clkbuf_pkg::*;
#(
  parameter int NUM_OUT     = 15,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_ok,
  input  logic [1:0]         mode_strap,
  input  logic               freq_strap,
  input  logic [NUM_OUT-1:0] out_clk_low,
  input  logic               fb_clk_low,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [NUM_OUT-1:0] out_gate,
  output logic               fb_gate,
  output logic               pll_en
);
  logic               run;
  pll_mode_e          mode_q;
  logic               freq_q;
  logic [NUM_OUT-1:0] enables;

  cb_pwr_seq #(.SYNC_STAGES(SYNC_STAGES)) u_pwr (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .mode_strap(mode_strap),
    .freq_strap(freq_strap), .run(run), .pll_en(pll_en),
    .mode_q(mode_q), .freq_q(freq_q)
  );

  cb_regfile #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode_q(mode_q), .freq_q(freq_q),
    .reg_rdata(reg_rdata), .enables(enables)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    cb_gate u_gate (
      .clk(clk), .rst(rst), .want(run & enables[i]),
      .clk_low(out_clk_low[i]), .gate(out_gate[i])
    );
  end

  cb_gate u_fb_gate (
    .clk(clk), .rst(rst), .want(run),
    .clk_low(fb_clk_low), .gate(fb_gate)
  );

  AST_PD_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run && (&out_clk_low) && fb_clk_low) |=> (out_gate == '0 && !fb_gate)); // R4
  AST_FB_RUN: assert property (@(posedge clk) disable iff (rst)
    (run && fb_clk_low) |=> fb_gate); // R6
endmodule

// File: tb/test_clkbuf_ctrl.sv
`timescale 1ns/1ps
module test_clkbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_ok = 1'b0;
  logic [1:0]  mode_strap = 2'b00;
  logic        freq_strap = 1'b0;
  logic [14:0] out_clk_low = '1;
  logic        fb_clk_low = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'b00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [14:0] out_gate;
  logic        fb_gate;
  logic        pll_en;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [14:0] x_en;
  logic [1:0]  x_mode;
  logic        x_freq;
  bit          x_started, x_run;

  always #10 clk = ~clk;

  clkbuf_ctrl i_clkbuf_ctrl (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .mode_strap(mode_strap),
    .freq_strap(freq_strap), .out_clk_low(out_clk_low), .fb_clk_low(fb_clk_low),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_gate(out_gate), .fb_gate(fb_gate), .pll_en(pll_en)
  );

  function automatic logic [1:0] map_mode(input logic [1:0] s);
    return (s == 2'b10) ? 2'b01 : s;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {x_mode, x_freq, 5'b0};
      2'd1:    return x_en[7:0];
      2'd2:    return {1'b0, x_en[14:8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd1) x_en[7:0]  = d;
    if (a == 2'd2) x_en[14:8] = d[6:0];
  endtask

  task automatic rd_check(input logic [1:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp_rd(a));
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R5 out_gate"}, out_gate, x_run ? x_en : 15'h0);
    chk({ctx, " R6 fb_gate"}, fb_gate, x_run);
    chk({ctx, " R7 pll_en"}, pll_en, x_run && x_mode != 2'b01);
    rd_check(2'd0, {ctx, " R2 byte0 straps"});
    rd_check(2'd1, {ctx, " R5 enable byte 1"});
    rd_check(2'd2, {ctx, " R9 enable byte 2"});
    rd_check(2'd3, {ctx, " R9 unused addr"});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pwr_ok = 1'b0;
    settle(3);
    rst = 1'b0;
    x_en = '1; x_mode = 2'b00; x_freq = 1'b0; x_started = 0; x_run = 0;
    settle(2);
  endtask

  task automatic pg_set(input logic v);
    @(negedge clk);
    if (v && !pwr_ok) begin
      if (!x_started) begin
        x_mode = map_mode(mode_strap); x_freq = freq_strap; x_started = 1;
      end
      x_run = 1;
    end
    if (!v) x_run = 0;
    pwr_ok = v;
    settle(6);
  endtask

  initial begin
    void'($urandom(32'd4242));
    settle(2);
    for (int m = 0; m < 4; m++) begin
      do_reset();
      chk("R1 reset gates off", {out_gate, fb_gate, pll_en}, 17'h0);
      mode_strap = m[1:0]; freq_strap = m[0];
      wr(2'd1, 8'hA5);
      settle(6);
      check_all("R1 before start");
      pg_set(1'b1);
      check_all("R2 after first rise");
      mode_strap = ~mode_strap; freq_strap = ~freq_strap;
      pg_set(1'b0);
      check_all("R4 power-down");
      pg_set(1'b1);
      check_all("R3 second rise");
    end

    for (int k = 0; k < 40; k++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: wr(2'd1, 8'($urandom));
        1: wr(2'd2, 8'($urandom));
        2: wr(($urandom % 2) ? 2'd3 : 2'd0, 8'($urandom));
        3: begin
             mode_strap = 2'($urandom); freq_strap = 1'($urandom);
             pg_set(~pwr_ok);
           end
        default: begin mode_strap = 2'($urandom); freq_strap = 1'($urandom); end
      endcase
      settle(6);
      check_all("R5 random");
    end

    // glitch-safe hold: output 5 clock held high
    if (!pwr_ok) pg_set(1'b1);
    wr(2'd1, 8'hFF);
    settle(6);
    out_clk_low[5] = 1'b0;
    wr(2'd1, 8'hDF);
    settle(6);
    chk("R8 gate held while clock high", out_gate[5], 1'b1);
    chk("R8 other outputs follow", out_gate[7:6], 2'b11);
    out_clk_low[5] = 1'b1;
    settle(6);
    chk("R8 gate updates when clock low", out_gate[5], 1'b0);
    fb_clk_low = 1'b0;
    pg_set(1'b0);
    chk("R8 fb gate held", fb_gate, 1'b1);
    fb_clk_low = 1'b1;
    settle(6);
    chk("R4 fb gate off after release", fb_gate, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule